// File: doc/BRIEF.md
# Buffered-Flag SPI Slave

This block is an SPI slave that moves 8-bit frames between a serial master and a register-style host port. Each direction has a single holding register. The transmit holding register feeds the output shift register, and a receive holding register catches each completed frame. The host sees three status flags. The transmit-empty flag says a new byte may be written. The receive-full flag says a byte is waiting to be read. The busy flag is high while a frame is being shifted. The host writes through a data write strobe and reads through a data read strobe. Control inputs select enable, receive-only operation, single-wire operation and, within single-wire operation, the line direction.

The select and serial clock inputs are resynchronised into the system clock with a two-stage register chain, and edges are found in that domain. The serial data inputs pass through a chain of the same depth, so each captured bit lines up with its clock edge. The serial clock half period must therefore be at least four system clocks. Clock polarity and phase are host inputs, so all four SPI modes work. The slave sends and receives the most significant bit first.

Because the transmit side is buffered, the host can place the next byte while the current one is still shifting. This lets the master run frames back to back. When no new byte has been written, the slave sends the last loaded byte again. When the host reads too late, the receive register takes the newest frame and the receive-full flag stays set.

Top module: `spi_slave_bufd`

## Requirements
- R1: After reset, transmit-empty is 1, receive-full is 0, busy is 0 and the output enable is 0.
- R2: After eight sampling edges, the frame is stored in the receive register, MSB first, and receive-full is set. A host read strobe clears receive-full unless a frame completes in the same cycle.
- R3: A host write clears transmit-empty. Transmit-empty is set again when the holding register is copied into the shift register at frame start, and that byte is sent MSB first.
- R4: No frame is shifted, no flag changes and no byte is stored while the select input is high or the block is disabled.
- R5: Busy is high from the first sampling edge of a frame to its eighth. With back-to-back frames, busy stays low for at least one full serial clock period between them.
- R6: With receive-only set and single-wire clear, the output enable stays 0 and no transmit handoff occurs: transmit-empty keeps its value. Reception still works.
- R7: All polarity and phase settings work. With phase 0, data is captured on the first edge of each bit. With phase 1, it is captured on the second edge. With polarity 1, the clock idles high.
- R8: If transmit-empty is still 1 when a new frame starts, the last loaded byte is sent again.
- R9: If a frame completes while receive-full is set, receive-full stays 1 and the read data becomes the newest frame.
- R10: Single-wire mode with the direction bit set drives the MISO pin while selected and stores no received frames. With the direction bit clear, it releases the pin and receives from the MISO pin instead of MOSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| rx_only | input | 1 | Receive-only select (two-wire mode) |
| bidi_mode | input | 1 | Single-wire mode select |
| bidi_out | input | 1 | Single-wire direction: 1 drives, 0 listens |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Capture on second edge when 1 |
| dr_wr | input | 1 | Host data write strobe |
| dr_wdata | input | 8 | Host write data |
| dr_rd | input | 1 | Host data read strobe |
| dr_rdata | output | 8 | Receive holding register |
| txe | output | 1 | Transmit holding register empty |
| rxne | output | 1 | Receive holding register full |
| bsy | output | 1 | Frame in progress |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| miso_i | input | 1 | MISO pin input, used in single-wire receive |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO pin output enable |

## Verification
The bench runs continuous multi-frame transfers in modes 0 and 3 and measures the busy-low gap between frames. A design that drops busy only briefly would show a gap of a few system clocks instead of a full serial period. It skips the host write before a frame to check resend of the previous byte. A design that shifted out zeros or stale shift contents there would be caught. It withholds reads across two frames to expose a design that keeps the older byte or clears the flag on overrun. It also exercises the receive-only and both single-wire settings. In single-wire receive, MOSI carries the inverse of the MISO data, so a design that listens on the wrong pin returns the complement.

// File: rtl/spi_slave_bufd.sv
module spi_slave_bufd #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rx_only,
  input  logic         bidi_mode,
  input  logic         bidi_out,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         dr_wr,
  input  logic [W-1:0] dr_wdata,
  input  logic         dr_rd,
  output logic [W-1:0] dr_rdata,
  output logic         txe,
  output logic         rxne,
  output logic         bsy,
  input  logic         ss_n,
  input  logic         sck,
  input  logic         mosi,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [SYNC:0]   sck_q;
  logic [SYNC-1:0] ss_q, mo_q, mi_q;
  logic            act_d;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    txsh, rxsh, tx_buf, rx_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      ss_q  <= '1;
      mo_q  <= '0;
      mi_q  <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], sck};
      ss_q  <= {ss_q[SYNC-2:0], ss_n};
      mo_q  <= {mo_q[SYNC-2:0], mosi};
      mi_q  <= {mi_q[SYNC-2:0], miso_i};
    end

  wire sck_now  = sck_q[SYNC-1] ^ cpol;
  wire sck_prev = sck_q[SYNC]   ^ cpol;
  wire lead     = sck_now & ~sck_prev;
  wire trail    = ~sck_now & sck_prev;
  wire act      = en & ~ss_q[SYNC-1];
  wire samp     = act & (cpha ? trail : lead);
  wire shft     = act & (cpha ? lead : trail);
  wire tx_path  = bidi_mode ? bidi_out : ~rx_only;
  wire rx_path  = ~bidi_mode | ~bidi_out;
  wire din      = bidi_mode ? mi_q[SYNC-1] : mo_q[SYNC-1];
  wire first    = (cnt == '0);
  wire done     = samp & (cnt == LAST);
  wire start    = cpha ? shft : (shft | (act & ~act_d));
  wire load     = tx_path & start & first;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_d <= 1'b0;
      cnt   <= '0;
      bsy   <= 1'b0;
      rxsh  <= '0;
    end else begin
      act_d <= act;
      if (!act) begin
        cnt <= '0;
        bsy <= 1'b0;
      end else if (samp) begin
        cnt  <= done ? '0 : cnt + 1'b1;
        bsy  <= ~done;
        rxsh <= {rxsh[W-2:0], din};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_buf <= '0;
      txsh   <= '0;
      txe    <= 1'b1;
    end else begin
      if (load)
        txsh <= tx_buf;
      else if (shft && !first)
        txsh <= {txsh[W-2:0], 1'b0};
      if (dr_wr) begin
        tx_buf <= dr_wdata;
        txe    <= 1'b0;
      end else if (load)
        txe <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_buf <= '0;
      rxne   <= 1'b0;
    end else if (done && rx_path) begin
      rx_buf <= {rxsh[W-2:0], din};
      rxne   <= 1'b1;
    end else if (dr_rd)
      rxne <= 1'b0;

  assign dr_rdata = rx_buf;
  assign miso_o   = txsh[W-1];
  assign miso_oe  = act & tx_path;
endmodule

module spi_slave_bufd_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic rx_only,
  input logic bidi_mode,
  input logic bidi_out,
  input logic dr_wr,
  input logic dr_rd,
  input logic txe,
  input logic rxne,
  input logic bsy,
  input logic miso_oe,
  input logic done,
  input logic load
);
  a_r3_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !txe);
  a_r3_txe_set_on_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe) |-> $past(load));
  a_r2_rxne_set_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> $past(done));
  a_r2_read_clears_rxne: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && !done) |=> !rxne);
  a_r5_bsy_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bsy);
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bsy && !miso_oe));
  a_r6_rxonly_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_only && !bidi_mode) |-> !miso_oe);
  a_r10_bidi_in_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bidi_mode && !bidi_out) |-> !miso_oe);
endmodule

bind spi_slave_bufd spi_slave_bufd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rx_only(rx_only), .bidi_mode(bidi_mode),
  .bidi_out(bidi_out), .dr_wr(dr_wr), .dr_rd(dr_rd), .txe(txe), .rxne(rxne),
  .bsy(bsy), .miso_oe(miso_oe), .done(done), .load(load));

// File: tb/test_spi_slave_bufd.sv
module test_spi_slave_bufd;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic en = 0, rx_only = 0, bidi_mode = 0, bidi_out = 0, cpol = 0, cpha = 0;
  logic dr_wr = 0, dr_rd = 0;
  logic [7:0] dr_wdata = 0, dr_rdata;
  logic txe, rxne, bsy, miso_o, miso_oe;
  logic ss_n = 1, sck = 0, mosi = 0, miso_i = 0;

  int nchk = 0, nfail = 0;
  logic [7:0] mst_q[$], rx_exp[$], tx_exp[$], feed[$];
  bit auto_rd = 1, tx_chk = 1, oe_seen = 0;
  int gap_cnt = 0, min_gap = 1000;
  bit seen_bsy = 0;

  always #5 clk = ~clk;

  spi_slave_bufd i_spi_slave_bufd (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_only(rx_only), .bidi_mode(bidi_mode),
    .bidi_out(bidi_out), .cpol(cpol), .cpha(cpha), .dr_wr(dr_wr),
    .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(dr_rdata), .txe(txe),
    .rxne(rxne), .bsy(bsy), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_frames(input int n);
    ss_n = 0;
    wclk(H);
    for (int f = 0; f < n; f++) begin
      logic [7:0] b, got;
      b = mst_q.pop_front();
      got = 0;
      for (int i = 7; i >= 0; i--) begin
        if (!cpha) begin
          mosi = b[i]; miso_i = ~b[i];
          wclk(H); sck = ~cpol; got[i] = miso_o;
          wclk(H); sck = cpol;
        end else begin
          sck = ~cpol; mosi = b[i]; miso_i = ~b[i];
          wclk(H); sck = cpol; got[i] = miso_o;
          wclk(H);
        end
      end
      if (tx_chk) begin
        logic [7:0] e;
        e = tx_exp.size() ? tx_exp.pop_front() : 8'hxx;
        chk(got === e, "R3", "MISO byte", got, e);
      end
    end
    wclk(H);
    ss_n = 1;
    wclk(4 * H);
  endtask

  initial forever begin
    @(negedge clk);
    if (auto_rd && rxne) begin
      logic [7:0] e;
      e = rx_exp.size() ? rx_exp.pop_front() : 8'hxx;
      chk(dr_rdata === e, "R2", "received byte", dr_rdata, e);
      dr_rd = 1; @(negedge clk); dr_rd = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (en && txe && feed.size() != 0) begin
      dr_wdata = feed.pop_front();
      tx_exp.push_back(dr_wdata);
      dr_wr = 1; @(negedge clk); dr_wr = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (miso_oe) oe_seen = 1;
    if (ss_n) begin seen_bsy = 0; gap_cnt = 0; end
    else if (bsy) begin
      if (seen_bsy && gap_cnt > 0 && gap_cnt < min_gap) min_gap = gap_cnt;
      seen_bsy = 1; gap_cnt = 0;
    end else if (seen_bsy) gap_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p;
    wclk(8);
  endtask

  initial begin
    wclk(3);
    chk(txe === 1 && rxne === 0 && bsy === 0 && miso_oe === 0, "R1", "reset flags",
        {txe, rxne, bsy, miso_oe}, 4'b1000);
    rst_n = 1;
    wclk(2);

    // R7 mode 0, continuous frames
    set_mode(0, 0);
    en = 1;
    feed = '{8'hA5, 8'h3C, 8'hF0};
    wclk(4);
    chk(txe === 0, "R3", "txe after write", txe, 0);
    mst_q = '{8'h5A, 8'hC3, 8'h0F}; rx_exp = '{8'h5A, 8'hC3, 8'h0F};
    min_gap = 1000;
    master_frames(3);
    chk(rx_exp.size() == 0, "R2", "mode0 frames left", rx_exp.size(), 0);
    chk(tx_exp.size() == 0, "R7", "mode0 tx left", tx_exp.size(), 0);
    chk(min_gap >= 2 * H - 2 && min_gap < 1000, "R5", "bsy gap mode0", min_gap, 2 * H);
    chk(txe === 1, "R3", "txe after handoff", txe, 1);

    // R7 mode 3, continuous frames
    set_mode(1, 1);
    feed = '{8'h81, 8'h7E};
    wclk(4);
    mst_q = '{8'h69, 8'hD2}; rx_exp = '{8'h69, 8'hD2};
    min_gap = 1000;
    master_frames(2);
    chk(rx_exp.size() == 0 && tx_exp.size() == 0, "R7", "mode3 leftovers",
        rx_exp.size() + tx_exp.size(), 0);
    chk(min_gap >= 2 * H - 2 && min_gap < 1000, "R5", "bsy gap mode3", min_gap, 2 * H);

    // R8 resend when no write
    feed = '{8'h96};
    wclk(4);
    tx_exp.push_back(8'h96);
    mst_q = '{8'h12, 8'h34}; rx_exp = '{8'h12, 8'h34};
    master_frames(2);
    chk(tx_exp.size() == 0, "R8", "resend count", tx_exp.size(), 0);

    // R9 overrun
    auto_rd = 0; tx_chk = 0;
    mst_q = '{8'h11, 8'h22};
    master_frames(2);
    chk(rxne === 1, "R9", "rxne on overrun", rxne, 1);
    chk(dr_rdata === 8'h22, "R9", "newest byte kept", dr_rdata, 8'h22);
    dr_rd = 1; wclk(1); dr_rd = 0; wclk(1);
    chk(rxne === 0, "R2", "read clears rxne", rxne, 0);

    // R4 select high, then disabled
    for (int i = 0; i < 16; i++) begin sck = ~sck; mosi = i[0]; wclk(H); end
    chk(rxne === 0 && bsy === 0, "R4", "ss_n high ignored", {rxne, bsy}, 0);
    en = 0; wclk(2);
    mst_q = '{8'hEE};
    master_frames(1);
    chk(rxne === 0 && bsy === 0, "R4", "disabled ignored", {rxne, bsy}, 0);
    en = 1; auto_rd = 1;

    // R6 receive-only
    rx_only = 1;
    feed = '{8'h77};
    wclk(4);
    oe_seen = 0;
    mst_q = '{8'h3E}; rx_exp = '{8'h3E};
    master_frames(1);
    chk(oe_seen == 0, "R6", "rx-only drive", oe_seen, 0);
    chk(txe === 0, "R6", "no handoff", txe, 0);
    chk(rx_exp.size() == 0, "R6", "rx-only receive", rx_exp.size(), 0);
    rx_only = 0;

    // R10 single wire, driving
    bidi_mode = 1; bidi_out = 1; tx_chk = 1; oe_seen = 0;
    mst_q = '{8'h55};
    master_frames(1);
    chk(oe_seen == 1, "R10", "bidi out drives", oe_seen, 1);
    chk(rxne === 0, "R10", "bidi out no store", rxne, 0);
    chk(tx_exp.size() == 0, "R10", "bidi out byte", tx_exp.size(), 0);

    // R10 single wire, listening on MISO pin
    bidi_out = 0; tx_chk = 0; oe_seen = 0;
    mst_q = '{8'hC9}; rx_exp = '{8'h36};
    master_frames(1);
    chk(oe_seen == 0, "R10", "bidi in released", oe_seen, 0);
    chk(rx_exp.size() == 0, "R10", "bidi in receive", rx_exp.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule